// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block turns one request from the CPU side into one complete read or write cycle on an external memory bus. The requester supplies an address, a direction, write data and a set of timing and format settings. These settings come from whichever bus-configuration set an address decoder outside this block has chosen. The sequencer copies the settings when it accepts the request. It then walks through an address phase, an optional read/write delay, a data strobe phase and, after reads, an optional bus recovery clock. It drives the address latch strobe, the active-low read and write strobes, the shared address/data port with its output enable, and a separate upper address port.

One engine serves four bus formats: multiplexed or demultiplexed, each with 8-bit or 16-bit data. The address is limited to 16, 18, 20 or 24 bits. A strobe can be stretched by a programmed number of wait states. It can also be held until an external ready line shows a programmable active level. When the external bus is disabled, the block ignores requests.

Top module: `ext_bus_seq`

## Requirements
- R1: While `ext_en` is 0, a request is ignored: `busy` stays 0, `done` stays 0, and `rd_n`, `wr_n` stay 1 and `ale` stays 0.
- R2: An accepted request (`req_valid` high at a clock edge while `busy` is 0 and `ext_en` is 1) raises `ale` in the next clock. `ale` lasts 1 clock, or 2 clocks when `cfg_ale_ext` is 1. Both strobes stay high while `ale` is high.
- R3: `cfg_aw_sel` 0/1/2/3 limits the address to 16/18/20/24 bits, with upper bits forced to 0. With `cfg_mux`=0, `addr_out` carries the limited address from the address phase through the strobe. With `cfg_mux`=1, `addr_out` carries only the limited bits at and above bit 16, and `ad_out` carries address bits 15:0 with `ad_oe`=1 while `ale` is high.
- R4: With `cfg_rw_dly`=1, one clock with no `ale` and no strobe separates the address phase from the strobe.
- R5: With the ready function off, the strobe (`rd_n` or `wr_n` low) lasts `cfg_waits`+1 clocks (4-bit count).
- R6: With `cfg_rdy_en`=1, once the wait count is used up the strobe continues until `rdy_in` equals `cfg_rdy_pol` at a clock edge. The cycle ends at that edge.
- R7: During the delay and strobe clocks of a write, `ad_oe`=1. `ad_out` then equals the 16-bit write data, or 8'h00 over the write data's low byte when `cfg_bus8`=1.
- R8: `ad_oe` is 0 in every read strobe clock. On the edge that ends a read, `rdata` takes `ad_in`, or 8'h00 over `ad_in[7:0]` when `cfg_bus8`=1, and holds that value afterwards.
- R9: `done` is high for exactly the one clock after the edge that ends the strobe.
- R10: After a read with `cfg_tri`=1, `busy` stays 1 during the `done` clock, and a request in that clock is not accepted. After writes, or when `cfg_tri`=0, `busy` is 0 in the `done` clock.
- R11: After reset, `busy`, `done` and `ale` are 0, both strobes are 1, `ad_oe` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | External bus enabled (0 = single-chip, requests ignored) |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | 16 | Write data |
| cfg_mux | input | 1 | 1 = multiplexed address/data port |
| cfg_bus8 | input | 1 | 1 = 8-bit data |
| cfg_aw_sel | input | 2 | Address width select 16/18/20/24 |
| cfg_ale_ext | input | 1 | Extra address-phase clock |
| cfg_waits | input | 4 | Wait states |
| cfg_rw_dly | input | 1 | Delay strobe by one clock |
| cfg_tri | input | 1 | Recovery clock after reads |
| cfg_rdy_en | input | 1 | Ready function enabled |
| cfg_rdy_pol | input | 1 | Active level of ready |
| rdy_in | input | 1 | External ready |
| ad_in | input | 16 | Data read from the address/data port |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Cycle-end pulse |
| rdata | output | 16 | Captured read data |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Address port |
| ad_out | output | 16 | Address/data port output value |
| ad_oe | output | 1 | Address/data port output enable |

## Verification
Every output is decoded from registered state, so each result is due a fixed number of clocks after the accepting edge. `ale` is due in clock 1. The strobe starts in clock 2 + ale_ext + rw_dly and ends at the edge that closes clock max(start + waits, ready-release clock). `done`, `rdata` and the recovery `busy` are due in the clock after that edge. The bench numbers the clocks from the accepting edge and samples each one at the falling edge. It computes these positions from each vector's settings and compares the recorded `ale` length, strobe start, strobe length and `done` position against them. It changes `rdy_in` only after that clock's sample, so the design sees it at the closing edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int WAIT_W = 4;
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int LOW_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DLY,
        ST_STRB,
        ST_RCV
    } ebs_state_e;

    typedef struct packed {
        logic              mux;
        logic              bus8;
        logic [1:0]        aw_sel;
        logic              ale_ext;
        logic [WAIT_W-1:0] waits;
        logic              rw_dly;
        logic              tri_rcv;
        logic              rdy_en;
        logic              rdy_pol;
    } ebs_cfg_t;

    function automatic int aw_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
    import ebs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_en,
    input  logic       req_valid,
    input  logic       req_write,
    input  ebs_cfg_t   cfg_in,
    input  logic       rdy_in,
    output ebs_state_e state,
    output ebs_cfg_t   cfg_q,
    output logic       write_q,
    output logic       accept,
    output logic       term,
    output logic       done
);

    logic              ph_extra;
    logic [WAIT_W-1:0] wcnt;
    logic              ready_ok;

    assign accept   = (state == ST_IDLE) && req_valid && ext_en;
    assign ready_ok = !cfg_q.rdy_en || (rdy_in == cfg_q.rdy_pol);
    assign term     = (state == ST_STRB) && (wcnt == '0) && ready_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            write_q  <= 1'b0;
            ph_extra <= 1'b0;
            wcnt     <= '0;
            done     <= 1'b0;
        end else begin
            done <= term;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q    <= cfg_in;
                        write_q  <= req_write;
                        ph_extra <= cfg_in.ale_ext;
                        state    <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (ph_extra) begin
                        ph_extra <= 1'b0;
                    end else begin
                        wcnt  <= cfg_q.waits;
                        state <= cfg_q.rw_dly ? ST_DLY : ST_STRB;
                    end
                end
                ST_DLY: state <= ST_STRB;
                ST_STRB: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - 1'b1;
                    end else if (ready_ok) begin
                        state <= (!write_q && cfg_q.tri_rcv) ? ST_RCV : ST_IDLE;
                    end
                end
                ST_RCV:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R9
    AST_READY_LEVEL_AT_END: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_q.rdy_en) |-> ($past(rdy_in) == cfg_q.rdy_pol));  // R6
    AST_SINGLE_CHIP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ext_en && state == ST_IDLE) |=> (state == ST_IDLE));  // R1

endmodule

// File: rtl/ebs_datapath.sv
module ebs_datapath
    import ebs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              term,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  ebs_state_e        state,
    input  ebs_cfg_t          cfg_q,
    input  logic              write_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [AW-1:0]     addr_out,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [AW-1:0] LOW_MASK = AW'({LOW_W{1'b1}});

    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [AW-1:0]     width_mask;
    logic [AW-1:0]     addr_m;
    logic              addr_live;
    logic              dphase;
    logic              strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (term && !write_q) begin
                rdata <= cfg_q.bus8 ? {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]} : ad_in;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < AW; i++) begin
            width_mask[i] = (i < aw_bits(cfg_q.aw_sel));
        end
    end

    assign addr_m    = addr_q & width_mask;
    assign addr_live = (state == ST_ADDR) || (state == ST_DLY) || (state == ST_STRB);
    assign dphase    = (state == ST_DLY) || (state == ST_STRB);
    assign strobe    = (state == ST_STRB);

    assign ale  = (state == ST_ADDR);
    assign rd_n = !(strobe && !write_q);
    assign wr_n = !(strobe && write_q);

    assign addr_out = !addr_live ? '0 : (cfg_q.mux ? (addr_m & ~LOW_MASK) : addr_m);

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (ale && cfg_q.mux) begin
            ad_out = addr_m[DATA_W-1:0];
            ad_oe  = 1'b1;
        end else if (dphase && write_q) begin
            ad_out = cfg_q.bus8 ? {{BYTE_W{1'b0}}, wdata_q[BYTE_W-1:0]} : wdata_q;
            ad_oe  = 1'b1;
        end
    end

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);  // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));  // R5
    AST_ALE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));  // R2
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);  // R7

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    input  logic              cfg_mux,
    input  logic              cfg_bus8,
    input  logic [1:0]        cfg_aw_sel,
    input  logic              cfg_ale_ext,
    input  logic [3:0]        cfg_waits,
    input  logic              cfg_rw_dly,
    input  logic              cfg_tri,
    input  logic              cfg_rdy_en,
    input  logic              cfg_rdy_pol,
    input  logic              rdy_in,
    input  logic [15:0]       ad_in,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [AW-1:0]     addr_out,
    output logic [15:0]       ad_out,
    output logic              ad_oe
);

    ebs_cfg_t   cfg_in;
    ebs_cfg_t   cfg_q;
    ebs_state_e state;
    logic       write_q;
    logic       accept;
    logic       term;

    always_comb begin
        cfg_in.mux     = cfg_mux;
        cfg_in.bus8    = cfg_bus8;
        cfg_in.aw_sel  = cfg_aw_sel;
        cfg_in.ale_ext = cfg_ale_ext;
        cfg_in.waits   = cfg_waits;
        cfg_in.rw_dly  = cfg_rw_dly;
        cfg_in.tri_rcv = cfg_tri;
        cfg_in.rdy_en  = cfg_rdy_en;
        cfg_in.rdy_pol = cfg_rdy_pol;
    end

    assign busy = (state != ST_IDLE);

    ebs_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ext_en    (ext_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .cfg_in    (cfg_in),
        .rdy_in    (rdy_in),
        .state     (state),
        .cfg_q     (cfg_q),
        .write_q   (write_q),
        .accept    (accept),
        .term      (term),
        .done      (done)
    );

    ebs_datapath #(.AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .term      (term),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .state     (state),
        .cfg_q     (cfg_q),
        .write_q   (write_q),
        .ad_in     (ad_in),
        .addr_out  (addr_out),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rdata     (rdata)
    );

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && ale));  // R2

endmodule

// File: tb/ext_bus_seq_bench.sv
module ext_bus_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_mux = 1'b0, cfg_bus8 = 1'b0, cfg_ale_ext = 1'b0;
    logic [1:0]  cfg_aw_sel = '0;
    logic [3:0]  cfg_waits = '0;
    logic        cfg_rw_dly = 1'b0, cfg_tri = 1'b0, cfg_rdy_en = 1'b0, cfg_rdy_pol = 1'b0;
    logic        rdy_in = 1'b0;
    logic [15:0] ad_in = '0;
    logic        busy, done, ale, rd_n, wr_n, ad_oe;
    logic [15:0] rdata, ad_out;
    logic [23:0] addr_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ext_bus_seq #(.AW(24)) u_ext_bus_seq (
        .clk(clk), .rst(rst), .ext_en(ext_en), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_mux(cfg_mux), .cfg_bus8(cfg_bus8), .cfg_aw_sel(cfg_aw_sel),
        .cfg_ale_ext(cfg_ale_ext), .cfg_waits(cfg_waits), .cfg_rw_dly(cfg_rw_dly),
        .cfg_tri(cfg_tri), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_pol(cfg_rdy_pol),
        .rdy_in(rdy_in), .ad_in(ad_in), .busy(busy), .done(done), .rdata(rdata),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_out(addr_out),
        .ad_out(ad_out), .ad_oe(ad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic        mux;
        logic        b8;
        logic [1:0]  aws;
        logic        alx;
        logic [3:0]  ws;
        logic        rwd;
        logic        tr;
        logic        ren;
        logic        rpol;
        logic [5:0]  rel;
        logic [23:0] addr;
        logic [15:0] wd;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  24'hABCDEF, 16'h0000, 16'h1234},
        '{1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  24'hFF5A5A, 16'hBEEF, 16'h0000},
        '{1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0,  24'hFFC0DE, 16'h0000, 16'h9A7C},
        '{1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0,  24'h3F1234, 16'hCAFE, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 2'd3, 1'b1, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0, 24'h876543, 16'h0000, 16'h55AA},
        '{1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5,  24'h000100, 16'h0000, 16'hC3C3},
        '{1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd7,  24'h0F0F0F, 16'h7711, 16'h0000},
        '{1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2,  24'h2A0042, 16'h0000, 16'h0F0F},
        '{1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd0,  24'hFFFFFF, 16'h0000, 16'hEE11}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] amask(input logic [1:0] s);
        case (s)
            2'd0: return 24'h00FFFF;
            2'd1: return 24'h03FFFF;
            2'd2: return 24'h0FFFFF;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int ale_n = 0, first_s = 0, strb_n = 0, done_k = 0;
        logic addr_ok = 1'b1, data_ok = 1'b1, busy_at_done = 1'b0;
        logic [15:0] rd_at_done = '0;
        logic [23:0] am = v.addr & amask(v.aws);
        int exp_fs = 2 + int'(v.alx) + int'(v.rwd);
        int exp_end = (exp_fs + int'(v.ws) > int'(v.rel)) ? exp_fs + int'(v.ws) : int'(v.rel);
        logic [15:0] exp_wd = v.b8 ? {8'h00, v.wd[7:0]} : v.wd;
        logic [15:0] exp_rd = v.b8 ? {8'h00, v.rd[7:0]} : v.rd;
        @(negedge clk);
        ext_en = 1'b1; req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.wd; cfg_mux = v.mux; cfg_bus8 = v.b8; cfg_aw_sel = v.aws;
        cfg_ale_ext = v.alx; cfg_waits = v.ws; cfg_rw_dly = v.rwd; cfg_tri = v.tr;
        cfg_rdy_en = v.ren; cfg_rdy_pol = v.rpol; ad_in = v.rd;
        rdy_in = (v.rel == 0) ? v.rpol : ~v.rpol;
        for (int k = 1; k < 60; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (ale) begin
                ale_n++;
                if (v.mux) begin
                    if (addr_out != (am & 24'hFF0000) || ad_out != am[15:0] || !ad_oe) addr_ok = 1'b0;
                end else if (addr_out != am) addr_ok = 1'b0;
            end
            if (!rd_n || !wr_n) begin
                if (first_s == 0) first_s = k;
                strb_n++;
                if (v.wr && (!ad_oe || ad_out != exp_wd || wr_n)) data_ok = 1'b0;
                if (!v.wr && (ad_oe || rd_n)) data_ok = 1'b0;
                if (!v.mux && addr_out != am) addr_ok = 1'b0;
            end
            if (done) begin
                done_k = k; busy_at_done = busy; rd_at_done = rdata;
                break;
            end
            rdy_in = (k >= int'(v.rel)) ? v.rpol : ~v.rpol;
        end
        chk(ale_n == 1 + int'(v.alx), "R2 ale length", ale_n, 1 + int'(v.alx));
        chk(addr_ok, "R3 address on ports", addr_out, am);
        chk(first_s == exp_fs, "R4 strobe start", first_s, exp_fs);
        chk(strb_n == exp_end - exp_fs + 1, v.ren ? "R6 ready-stretched strobe" : "R5 strobe length",
            strb_n, exp_end - exp_fs + 1);
        chk(done_k == exp_end + 1, "R9 done position", done_k, exp_end + 1);
        if (v.wr) chk(data_ok, "R7 write data drive", ad_out, exp_wd);
        else begin
            chk(data_ok, "R8 read strobe undriven", ad_oe, 0);
            chk(rd_at_done == exp_rd, "R8 read capture", rd_at_done, exp_rd);
        end
        chk(busy_at_done == (!v.wr && v.tr), "R10 recovery busy", busy_at_done, !v.wr && v.tr);
        @(negedge clk);
        chk(!done, "R9 done single clock", done, 0);
        chk(!busy, "R10 idle after cycle", busy, 0);
        rdy_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe && rdata == 0,
            "R11 reset state", {busy, done, ale, rd_n, wr_n, ad_oe}, 6'b000110);
        rst = 1'b0;

        // R1: single-chip setting ignores requests
        @(negedge clk);
        ext_en = 1'b0; req_valid = 1'b1; req_write = 1'b1; cfg_waits = 4'd0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!busy && !done && !ale && rd_n && wr_n, "R1 single-chip ignored",
                {busy, done, ale, rd_n, wr_n}, 5'b00011);
        end
        req_valid = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R10: request during the recovery clock is held off one clock
        @(negedge clk);
        ext_en = 1'b1; req_valid = 1'b1; req_write = 1'b0; cfg_mux = 1'b0; cfg_bus8 = 1'b0;
        cfg_ale_ext = 1'b0; cfg_waits = 4'd0; cfg_rw_dly = 1'b0; cfg_tri = 1'b1; cfg_rdy_en = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(done && busy, "R10 recovery clock", {done, busy}, 2'b11);
        req_valid = 1'b1;
        @(negedge clk);
        chk(!ale && !busy, "R10 request held off", {ale, busy}, 2'b00);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale && busy, "R10 request taken after recovery", {ale, busy}, 2'b11);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule